// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block sequences the drive of a passive, time-multiplexed liquid crystal panel with `NCOM` common electrodes and `NSEG` segment lines. For every electrode it emits a 3-bit tap index. External analog switches use that index to connect the electrode to one tap of a five-tap resistor ladder. The taps are ground (code 0), a lower intermediate tap (code 1), the mid reference (code 2), an upper intermediate tap (code 3) and the top rail (code 4).

Each slot strobes one common. Every segment line is then placed on the tap that either widens or narrows its difference to that strobe, according to the on/off bit for the crossing of that segment and the strobed common. A full drive cycle contains `2*NCOM` slots, so every common is strobed once with each polarity and each electrode carries no net DC.

Two slot orderings can be selected. The first is a whole-scan ordering, in which a positive scan is followed by a negative scan. The second is a pulse-pair ordering, in which each common receives its positive and negative strobe back to back. Two tap mappings can also be selected: a half-select mapping and a third-select mapping. Slots advance on an external slot-rate enable. The system integrator derives this enable from the system clock, typically so that a full cycle repeats at about 40 Hz, and above 30 Hz.

Top module: `lcd_mux_seq`

## Requirements
- R1: A drive cycle has exactly `2*NCOM` slots. The slot position advances by one on each clock with `slot_tick` high, wraps after the last slot, and never changes on a clock with `slot_tick` low.
- R2: With `ord_pair` = 0, slot s of a cycle with s < NCOM strobes common s with positive polarity. Slot s with s >= NCOM strobes common s-NCOM with negative polarity.
- R3: With `ord_pair` = 1, slot 2k strobes common k with positive polarity and slot 2k+1 strobes common k with negative polarity.
- R4: With `third_sel` = 0 (half-select), the strobed common is driven to code 4 when positive and code 0 when negative. All other commons are driven to code 2. A segment whose bit is on is driven to code 1 in a positive slot and code 3 in a negative slot. An off segment is driven to code 3 in a positive slot and code 1 in a negative slot.
- R5: With `third_sel` = 1 (third-select), the strobed common is driven to code 4 when positive and code 0 when negative. Unstrobed commons are driven to code 1 in a positive slot and code 3 in a negative slot. An on segment is driven to code 0 in a positive slot and code 4 in a negative slot. An off segment is driven to code 3 in a positive slot and code 1 in a negative slot.
- R6: Over every complete drive cycle, the sum of (code - 2) is zero for every common and every segment output.
- R7: `seg_bits`, `ord_pair` and `third_sel` are sampled only on the tick that starts a cycle (slot 0). Changes made during a cycle have no effect until the next cycle begins.
- R8: While `rst` is high, and afterwards until the first `slot_tick`, every output is code 2. The first tick after reset starts slot 0.
- R9: The codes for a slot appear on the clock edge that samples its tick. They are held unchanged until the next tick.
- R10: Bit `k*NSEG + j` of `seg_bits` is the on/off bit for the crossing of common k and segment j. Common k uses bits `[3k+2:3k]` of `com_lvl`, and segment j uses bits `[3j+2:3j]` of `seg_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_tick | input | 1 | Slot-rate enable, one clock wide per slot |
| ord_pair | input | 1 | 0: whole-scan ordering, 1: pulse-pair ordering |
| third_sel | input | 1 | 0: half-select mapping, 1: third-select mapping |
| seg_bits | input | NCOM*NSEG | Frame of on/off bits, common-major |
| com_lvl | output | 3*NCOM | Tap code per common electrode |
| seg_lvl | output | 3*NSEG | Tap code per segment line |

## Verification
Every result is due exactly one clock edge after the tick that produces it, because the only registers between a tick and the outputs are the output registers. Frame and mode sampling happen on that same edge for slot 0. The bench drives inputs on falling edges, advances its behavioural model on the rising edge, and compares every output code against the model on the next falling edge, including clocks with no tick, where the outputs must hold. The zero-DC check sums the actual output codes, sampled on the falling edge after each tick, and tests the totals after every `2*NCOM` such slots.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;

  localparam int LVW = 3;
  typedef logic [LVW-1:0] lvl_t;

  localparam lvl_t LV_GND = 3'd0;
  localparam lvl_t LV_LO  = 3'd1;
  localparam lvl_t LV_REF = 3'd2;
  localparam lvl_t LV_HI  = 3'd3;
  localparam lvl_t LV_TOP = 3'd4;

  // Tap for a common electrode given strobe state and polarity
  function automatic lvl_t com_code(input logic strobed, input logic neg,
                                    input logic third);
    lvl_t c;
    if (strobed)     c = neg ? LV_GND : LV_TOP;
    else if (!third) c = LV_REF;
    else             c = neg ? LV_HI : LV_LO;
    return c;
  endfunction

  // Tap for a segment line given its bit and the strobe polarity
  function automatic lvl_t seg_code(input logic on, input logic neg,
                                    input logic third);
    lvl_t c;
    if (!third) c = (on ^ neg) ? LV_LO : LV_HI;
    else if (on) c = neg ? LV_TOP : LV_GND;
    else         c = neg ? LV_LO : LV_HI;
    return c;
  endfunction

endpackage

// File: rtl/lcd_slot_ctr.sv
module lcd_slot_ctr #(
  parameter int NCOM = 4,
  localparam int SW = $clog2(2*NCOM)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic [SW-1:0] slot,
  output logic          at_start
);
  localparam logic [SW-1:0] LAST = SW'(2*NCOM-1);

  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign slot     = cnt_q;
  assign at_start = (cnt_q == '0);

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);                                                   // R1
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));                                        // R1

endmodule

// File: rtl/lcd_slot_decode.sv
module lcd_slot_decode #(
  parameter int NCOM = 4,
  localparam int SW = $clog2(2*NCOM),
  localparam int CW = $clog2(NCOM)
) (
  input  logic [SW-1:0] slot,
  input  logic          pair,
  output logic [CW-1:0] com_idx,
  output logic          neg
);
  localparam logic [SW-1:0] NC_S = SW'(NCOM);

  logic [SW-1:0] half_slot;

  always_comb begin
    half_slot = slot >> 1;
    if (pair) begin
      neg     = slot[0];
      com_idx = CW'(half_slot);
    end else begin
      neg     = (slot >= NC_S);
      com_idx = neg ? CW'(slot - NC_S) : CW'(slot);
    end
  end

endmodule

// File: rtl/lcd_frame_latch.sv
module lcd_frame_latch #(
  parameter int NCOM = 4,
  parameter int NSEG = 8,
  localparam int CW = $clog2(NCOM)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [NCOM*NSEG-1:0] d_bits,
  input  logic                 d_pair,
  input  logic                 d_third,
  input  logic [CW-1:0]        rd_idx,
  output logic [NSEG-1:0]      rd_row,
  output logic                 pair_q,
  output logic                 third_q
);
  logic [NCOM-1:0][NSEG-1:0] rows_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rows_q  <= '0;
      pair_q  <= 1'b0;
      third_q <= 1'b0;
    end else if (load) begin
      rows_q  <= d_bits;
      pair_q  <= d_pair;
      third_q <= d_third;
    end
  end

  assign rd_row = rows_q[rd_idx];

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(rows_q) && $stable(pair_q) && $stable(third_q))); // R7

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
  import lcd_mux_pkg::*;
#(
  parameter int NCOM = 4,
  parameter int NSEG = 8,
  localparam int CW = $clog2(NCOM)
) (
  input  logic [CW-1:0]       com_idx,
  input  logic                neg,
  input  logic                third,
  input  logic [NSEG-1:0]     row,
  output logic [NCOM*LVW-1:0] com_codes,
  output logic [NSEG*LVW-1:0] seg_codes
);
  for (genvar k = 0; k < NCOM; k++) begin : g_com
    assign com_codes[k*LVW +: LVW] = com_code(com_idx == CW'(k), neg, third);
  end

  for (genvar j = 0; j < NSEG; j++) begin : g_seg
    assign seg_codes[j*LVW +: LVW] = seg_code(row[j], neg, third);
  end

endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
  import lcd_mux_pkg::*;
#(
  parameter int NCOM = 4,
  parameter int NSEG = 8,
  localparam int SW = $clog2(2*NCOM),
  localparam int CW = $clog2(NCOM)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 slot_tick,
  input  logic                 ord_pair,
  input  logic                 third_sel,
  input  logic [NCOM*NSEG-1:0] seg_bits,
  output logic [NCOM*3-1:0]    com_lvl,
  output logic [NSEG*3-1:0]    seg_lvl
);
  logic [SW-1:0]       slot;
  logic                at_start;
  logic                load;
  logic                pair_q, third_q, use_pair, use_third;
  logic [CW-1:0]       com_idx;
  logic                neg;
  logic [NSEG-1:0]     row_q, row_live, row;
  logic [NCOM*LVW-1:0] com_nx, com_q;
  logic [NSEG*LVW-1:0] seg_nx, seg_q;
  logic                started_q;

  lcd_slot_ctr #(.NCOM(NCOM)) u_ctr (
    .clk(clk), .rst(rst), .tick(slot_tick), .slot(slot), .at_start(at_start)
  );

  assign load      = slot_tick && at_start;
  // Slot 0 uses the inputs directly, as they are being captured on this edge
  assign use_pair  = at_start ? ord_pair  : pair_q;
  assign use_third = at_start ? third_sel : third_q;

  lcd_slot_decode #(.NCOM(NCOM)) u_dec (
    .slot(slot), .pair(use_pair), .com_idx(com_idx), .neg(neg)
  );

  lcd_frame_latch #(.NCOM(NCOM), .NSEG(NSEG)) u_fb (
    .clk(clk), .rst(rst), .load(load), .d_bits(seg_bits),
    .d_pair(ord_pair), .d_third(third_sel), .rd_idx(com_idx),
    .rd_row(row_q), .pair_q(pair_q), .third_q(third_q)
  );

  assign row_live = seg_bits[int'(com_idx)*NSEG +: NSEG];
  assign row      = at_start ? row_live : row_q;

  lcd_level_map #(.NCOM(NCOM), .NSEG(NSEG)) u_map (
    .com_idx(com_idx), .neg(neg), .third(use_third), .row(row),
    .com_codes(com_nx), .seg_codes(seg_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      com_q     <= {NCOM{LV_REF}};
      seg_q     <= {NSEG{LV_REF}};
      started_q <= 1'b0;
    end else if (slot_tick) begin
      com_q     <= com_nx;
      seg_q     <= seg_nx;
      started_q <= 1'b1;
    end
  end

  assign com_lvl = com_q;
  assign seg_lvl = seg_q;

  logic [NCOM-1:0] strobe_mask;
  for (genvar k = 0; k < NCOM; k++) begin : g_mask
    assign strobe_mask[k] = (com_q[k*LVW +: LVW] == LV_TOP) ||
                            (com_q[k*LVW +: LVW] == LV_GND);
  end

  AST_IDLE_AT_REF: assert property (@(posedge clk) disable iff (rst)
    !started_q |-> (com_q == {NCOM{LV_REF}} && seg_q == {NSEG{LV_REF}})); // R8
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    started_q |-> $countones(strobe_mask) == 1);                        // R2
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
    !slot_tick |=> ($stable(com_q) && $stable(seg_q)));                 // R9

endmodule

// File: tb/tb_lcd_mux_seq.sv
module tb_lcd_mux_seq;
  localparam int NCOM = 4;
  localparam int NSEG = 8;
  localparam int NSLOT = 2*NCOM;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slot_tick = 1'b0;
  logic ord_pair = 1'b0;
  logic third_sel = 1'b0;
  logic [NCOM*NSEG-1:0] seg_bits = '0;
  logic [NCOM*3-1:0] com_lvl;
  logic [NSEG*3-1:0] seg_lvl;

  always #10 clk = ~clk;  // 50 MHz

  lcd_mux_seq #(.NCOM(NCOM), .NSEG(NSEG)) dut (
    .clk(clk), .rst(rst), .slot_tick(slot_tick), .ord_pair(ord_pair),
    .third_sel(third_sel), .seg_bits(seg_bits),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  string tag = "R8";

  // ---------------- behavioural reference ----------------
  int m_slot = 0;
  logic [NCOM*NSEG-1:0] m_bits;
  bit m_pair, m_third, tick_seen;
  logic [NCOM*3-1:0] exp_com;
  logic [NSEG*3-1:0] exp_seg;

  always @(posedge clk) begin
    int c;
    bit ng, on;
    if (rst) begin
      m_slot = 0;
      exp_com = {NCOM{3'd2}};
      exp_seg = {NSEG{3'd2}};
    end else if (slot_tick) begin
      if (m_slot == 0) begin
        m_bits = seg_bits; m_pair = ord_pair; m_third = third_sel;
      end
      if (m_pair) begin c = m_slot / 2; ng = (m_slot % 2) == 1; end
      else begin c = m_slot % NCOM; ng = m_slot >= NCOM; end
      for (int k = 0; k < NCOM; k++) begin
        if (k == c)       exp_com[k*3 +: 3] = ng ? 3'd0 : 3'd4;
        else if (!m_third) exp_com[k*3 +: 3] = 3'd2;
        else              exp_com[k*3 +: 3] = ng ? 3'd3 : 3'd1;
      end
      for (int j = 0; j < NSEG; j++) begin
        on = m_bits[c*NSEG + j];
        if (!m_third) exp_seg[j*3 +: 3] = (on != ng) ? 3'd1 : 3'd3;
        else if (on)  exp_seg[j*3 +: 3] = ng ? 3'd4 : 3'd0;
        else          exp_seg[j*3 +: 3] = ng ? 3'd1 : 3'd3;
      end
      m_slot = (m_slot + 1) % NSLOT;
      tick_seen = 1;
    end
  end

  // ---------------- per-clock comparison and DC sums ----------------
  int dc_com[NCOM];
  int dc_seg[NSEG];
  int dc_cnt = 0;

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (com_lvl !== exp_com || seg_lvl !== exp_seg) begin
        fails++;
        $display("FAIL %s: com=%h seg=%h expected com=%h seg=%h",
                 tag, com_lvl, seg_lvl, exp_com, exp_seg);
      end
      if (tick_seen) begin
        tick_seen = 0;
        for (int k = 0; k < NCOM; k++) dc_com[k] += int'(com_lvl[k*3 +: 3]) - 2;
        for (int j = 0; j < NSEG; j++) dc_seg[j] += int'(seg_lvl[j*3 +: 3]) - 2;
        dc_cnt++;
        if (dc_cnt == NSLOT) begin
          vectors++;
          for (int k = 0; k < NCOM; k++)
            if (dc_com[k] != 0) begin
              fails++;
              $display("FAIL R6: common %0d dc sum=%0d expected 0", k, dc_com[k]);
            end
          for (int j = 0; j < NSEG; j++)
            if (dc_seg[j] != 0) begin
              fails++;
              $display("FAIL R6: segment %0d dc sum=%0d expected 0", j, dc_seg[j]);
            end
          for (int k = 0; k < NCOM; k++) dc_com[k] = 0;
          for (int j = 0; j < NSEG; j++) dc_seg[j] = 0;
          dc_cnt = 0;
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic one_slot(input int gap);
    @(negedge clk) slot_tick = 1'b1;
    @(negedge clk) slot_tick = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic run_cycles(input int n, input int gap, input bit pr,
                            input bit th, input string t);
    tag = t;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ord_pair = pr; third_sel = th;
      seg_bits = {$urandom, $urandom};
      for (int s = 0; s < NSLOT; s++) one_slot(gap);
    end
  endtask

  initial begin
    for (int k = 0; k < NCOM; k++) dc_com[k] = 0;
    for (int j = 0; j < NSEG; j++) dc_seg[j] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    tag = "R8";
    repeat (6) @(negedge clk);                // idle after reset: reference codes

    run_cycles(3, 2, 1'b0, 1'b0, "R2 R4 R9");
    run_cycles(3, 2, 1'b1, 1'b0, "R3 R4 R9");
    run_cycles(3, 1, 1'b0, 1'b1, "R2 R5");
    run_cycles(3, 1, 1'b1, 1'b1, "R3 R5");
    run_cycles(4, 0, 1'b0, 1'b0, "R1 back-to-back");

    // R7: mid-cycle changes of frame and modes must wait for next cycle
    tag = "R7";
    @(negedge clk); ord_pair = 0; third_sel = 0; seg_bits = '0;
    for (int s = 0; s < NSLOT; s++) begin
      one_slot(1);
      if (s == 2) begin seg_bits = '1; ord_pair = 1; third_sel = 1; end
    end
    for (int s = 0; s < NSLOT; s++) one_slot(1);   // now uses the new settings

    // R10: single-bit frames locate each crossing
    tag = "R10";
    for (int b = 0; b < NCOM*NSEG; b += 5) begin
      @(negedge clk);
      seg_bits = '0; seg_bits[b] = 1'b1; ord_pair = b[0]; third_sel = b[1];
      for (int s = 0; s < NSLOT; s++) one_slot(0);
    end

    // all on and all off in both mappings
    tag = "R4 R5 R6";
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      seg_bits = v[0] ? '1 : '0; third_sel = v[1]; ord_pair = v[0];
      for (int s = 0; s < NSLOT; s++) one_slot(1);
    end

    tag = "R9 hold";
    repeat (10) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule